// File: doc/BRIEF.md
# Precision-Time Event Stamp Capture Latch

This block takes a snapshot of the free-running time counter whenever a timing-protocol event frame starts on the receive or transmit side. It holds that snapshot in a single slot per direction. Each slot locks once it has been filled and stays locked until software collects the upper half of the stamp. While a slot is locked, further qualifying frames in that direction are not stamped; they are counted as dropped events in a saturating per-direction counter.

On the receive side a header filter chooses which frames qualify. It looks at the EtherType, the IP protocol, the UDP source and destination ports, the protocol version and the message type, and it offers four selection modes. On the transmit side the frame-start strobe qualifies only when the frame is marked for stamping. Software reads stamps, a status word and the drop counters through a simple read port whose data arrives one cycle after the request. An interrupt pulse marks every new capture.

Top module: `ptp_stamp_latch`

## Requirements
- R1: On a qualifying frame-start strobe with the slot free, the slot stores the `time_now` value present in that strobe cycle. Read addresses are 0 (receive bits 31:0), 1 (receive bits 63:32), 2 (transmit bits 31:0) and 3 (transmit bits 63:32). `rd_data` shows the selected word in the cycle after `rd_en` and otherwise holds its last value.
- R2: A capture sets the direction's valid flag. While the flag is set, further qualifying strobes in that direction leave the stored stamp unchanged.
- R3: A read of the high word (address 1 for receive, 3 for transmit) clears that direction's valid flag at the same clock edge, whether or not the low word was read. A read of the low word clears nothing. A strobe that arrives in the same cycle as the clearing read is dropped.
- R4: With `cfg_rx_sel` = 0, the receive side stamps only frames with IP protocol 17, UDP destination port 319, version 1 and message type 0 (when `cfg_v1_delay` = 0) or message type 1 (when `cfg_v1_delay` = 1).
- R5: With `cfg_rx_sel` = 1, the receive side stamps version-2 frames with message type 0 to 3 that carry either EtherType 0x88F7 or the UDP port-319 match of R4.
- R6: With `cfg_rx_sel` = 2, every receive strobe qualifies. With `cfg_rx_sel` = 3, none does.
- R7: With `cfg_src_chk` = 1, the UDP match also requires source port 319. The EtherType match is not affected.
- R8: `cfg_rx_en` and `cfg_tx_en` gate the two directions independently, and a disabled direction never sets its valid flag. A transmit strobe qualifies only with `tx_mark` = 1.
- R9: A qualifying strobe that finds its slot locked increments that direction's drop counter, which saturates at 2^DROP_W-1. Address 5 reads the receive count and address 6 the transmit count, zero-extended. Address 4 reads status: bit 0 is the receive valid flag and bit 1 the transmit valid flag. Address 7 reads zero.
- R10: `irq` is high for exactly the first cycle in which either valid flag is high after being low, and it is low otherwise.
- R11: While in reset and right after it, both valid flags, `irq`, `rd_data` and both drop counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Receive capture enable |
| cfg_tx_en | input | 1 | Transmit capture enable |
| cfg_rx_sel | input | 2 | Receive selection mode (0 V1 UDP, 1 V2 event, 2 all, 3 none) |
| cfg_v1_delay | input | 1 | V1 mode message: 0 picks type 0, 1 picks type 1 |
| cfg_src_chk | input | 1 | Also require UDP source port 319 |
| time_now | input | TIME_W | Current time counter |
| rx_sof | input | 1 | Receive frame-start strobe |
| rx_etype | input | 16 | Receive frame EtherType |
| rx_ip_proto | input | 8 | Receive IP protocol number |
| rx_udp_src | input | 16 | Receive UDP source port |
| rx_udp_dst | input | 16 | Receive UDP destination port |
| rx_ptp_ver | input | 4 | Receive timing-protocol version |
| rx_msg_type | input | 4 | Receive timing-protocol message type |
| tx_sof | input | 1 | Transmit frame-start strobe |
| tx_mark | input | 1 | Transmit frame requests a stamp |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read address |
| rd_data | output | TIME_W/2 | Read data, one cycle after the request |
| rx_valid | output | 1 | Receive slot holds an uncollected stamp |
| tx_valid | output | 1 | Transmit slot holds an uncollected stamp |
| irq | output | 1 | One-cycle pulse on each new capture |

## Verification
The bench builds the block with DROP_W = 3, so a drop counter reaches its ceiling of 7 after a handful of strobes on a locked slot, and the saturation boundary is covered in a short run. TIME_W keeps its default of 64. The time counter starts just below a carry out of the low word, so stamps taken early and late in the run differ in the high word, and a swapped or truncated half shows up. Directed frames exercise each selection mode at its edges, such as message type 3 against 8 and source port 319 against another port. A randomized phase then mixes strobes, mode changes and clearing reads, and a behavioural model checks the result on every clock.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

  localparam logic [15:0] ETYPE_TIMING   = 16'h88F7;
  localparam logic [15:0] EVENT_UDP_PORT = 16'd319;
  localparam logic [7:0]  PROTO_UDP      = 8'd17;
  localparam logic [3:0]  VER_ONE        = 4'd1;
  localparam logic [3:0]  VER_TWO        = 4'd2;
  localparam logic [3:0]  V1_MSG_SYNC    = 4'd0;
  localparam logic [3:0]  V1_MSG_DELAY   = 4'd1;
  localparam logic [3:0]  V2_EVENT_LAST  = 4'd3;

  localparam int NDIR   = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  localparam logic [1:0] SYS_STATUS = 2'd0;
  localparam logic [1:0] SYS_RXDROP = 2'd1;
  localparam logic [1:0] SYS_TXDROP = 2'd2;

  typedef enum logic [1:0] {
    RXSEL_V1_UDP   = 2'd0,
    RXSEL_V2_EVENT = 2'd1,
    RXSEL_ANY      = 2'd2,
    RXSEL_NONE     = 2'd3
  } rx_sel_e;

  typedef struct packed {
    logic [15:0] etype;
    logic [7:0]  ip_proto;
    logic [15:0] udp_src;
    logic [15:0] udp_dst;
    logic [3:0]  ver;
    logic [3:0]  msg;
  } frame_hdr_t;

endpackage

// File: rtl/ptp_rx_filter.sv
module ptp_rx_filter
  import ptp_stamp_pkg::*;
(
  input  frame_hdr_t hdr,
  input  rx_sel_e    sel,
  input  logic       v1_delay,
  input  logic       src_chk,
  output logic       hit
);

  logic l2_hit;
  logic udp_dst_hit;
  logic udp_src_ok;
  logic l4_hit;
  logic v1_hit;
  logic v2_hit;
  logic [3:0] v1_want;

  always_comb begin
    l2_hit      = (hdr.etype == ETYPE_TIMING);
    udp_dst_hit = (hdr.ip_proto == PROTO_UDP) && (hdr.udp_dst == EVENT_UDP_PORT);
    udp_src_ok  = !src_chk || (hdr.udp_src == EVENT_UDP_PORT);
    l4_hit      = udp_dst_hit && udp_src_ok;
    v1_want     = v1_delay ? V1_MSG_DELAY : V1_MSG_SYNC;
    v1_hit      = l4_hit && (hdr.ver == VER_ONE) && (hdr.msg == v1_want);
    v2_hit      = (l2_hit || l4_hit) && (hdr.ver == VER_TWO) && (hdr.msg <= V2_EVENT_LAST);
  end

  always_comb begin
    case (sel)
      RXSEL_V1_UDP:   hit = v1_hit;
      RXSEL_V2_EVENT: hit = v2_hit;
      RXSEL_ANY:      hit = 1'b1;
      default:        hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot #(
  parameter int TIME_W = 64,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic              clear,
  input  logic [TIME_W-1:0] time_now,
  output logic              valid,
  output logic [TIME_W-1:0] stamp,
  output logic [DROP_W-1:0] drop_cnt,
  output logic              cap
);

  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic              valid_q;
  logic              valid_n;
  logic [TIME_W-1:0] stamp_q;
  logic [DROP_W-1:0] drop_q;
  logic [DROP_W-1:0] drop_n;
  logic              drop_hit;
  logic              drop_en;

  always_comb begin
    cap      = qual && !valid_q;
    drop_hit = qual && valid_q;
    drop_en  = drop_hit && (drop_q != DROP_MAX);
    drop_n   = drop_q + 1'b1;
    valid_n  = valid_q ? !clear : cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stamp_q <= '0;
    else if (cap) stamp_q <= time_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_q <= '0;
    else if (drop_en) drop_q <= drop_n;
  end

  assign valid    = valid_q;
  assign stamp    = stamp_q;
  assign drop_cnt = drop_q;

endmodule

// File: rtl/ptp_stamp_readout.sv
module ptp_stamp_readout
  import ptp_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DROP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [2:0]                   rd_addr,
  input  logic [NDIR-1:0][TIME_W-1:0]  dir_stamp,
  input  logic [NDIR-1:0]              dir_valid,
  input  logic [NDIR-1:0][DROP_W-1:0]  dir_drop,
  output logic [NDIR-1:0]              dir_clear,
  output logic [TIME_W/2-1:0]          rd_data
);

  localparam int HALF = TIME_W / 2;

  logic [HALF-1:0] rdata_q;
  logic [HALF-1:0] rdata_n;
  logic [HALF-1:0] stamp_word;
  logic [HALF-1:0] sys_word;

  for (genvar d = 0; d < NDIR; d++) begin : g_clear
    localparam logic [2:0] HI_ADDR = 3'(2 * d + 1);
    assign dir_clear[d] = rd_en && (rd_addr == HI_ADDR);
  end

  always_comb begin
    if (rd_addr[0]) stamp_word = dir_stamp[rd_addr[1]][TIME_W-1:HALF];
    else            stamp_word = dir_stamp[rd_addr[1]][HALF-1:0];
    case (rd_addr[1:0])
      SYS_STATUS: sys_word = HALF'(dir_valid);
      SYS_RXDROP: sys_word = HALF'(dir_drop[DIR_RX]);
      SYS_TXDROP: sys_word = HALF'(dir_drop[DIR_TX]);
      default:    sys_word = '0;
    endcase
    rdata_n = rd_addr[2] ? sys_word : stamp_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_n;
  end

  assign rd_data = rdata_q;

endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
  import ptp_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DROP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_rx_en,
  input  logic                cfg_tx_en,
  input  logic [1:0]          cfg_rx_sel,
  input  logic                cfg_v1_delay,
  input  logic                cfg_src_chk,
  input  logic [TIME_W-1:0]   time_now,
  input  logic                rx_sof,
  input  logic [15:0]         rx_etype,
  input  logic [7:0]          rx_ip_proto,
  input  logic [15:0]         rx_udp_src,
  input  logic [15:0]         rx_udp_dst,
  input  logic [3:0]          rx_ptp_ver,
  input  logic [3:0]          rx_msg_type,
  input  logic                tx_sof,
  input  logic                tx_mark,
  input  logic                rd_en,
  input  logic [2:0]          rd_addr,
  output logic [TIME_W/2-1:0] rd_data,
  output logic                rx_valid,
  output logic                tx_valid,
  output logic                irq
);

  frame_hdr_t                  rx_hdr;
  rx_sel_e                     rx_sel;
  logic                        rx_hit;
  logic [NDIR-1:0]             dir_qual;
  logic [NDIR-1:0]             dir_clear;
  logic [NDIR-1:0]             dir_valid;
  logic [NDIR-1:0]             dir_cap;
  logic [NDIR-1:0][TIME_W-1:0] dir_stamp;
  logic [NDIR-1:0][DROP_W-1:0] dir_drop;
  logic                        irq_q;
  logic                        irq_n;

  assign rx_hdr = '{etype:    rx_etype,
                    ip_proto: rx_ip_proto,
                    udp_src:  rx_udp_src,
                    udp_dst:  rx_udp_dst,
                    ver:      rx_ptp_ver,
                    msg:      rx_msg_type};
  assign rx_sel = rx_sel_e'(cfg_rx_sel);

  ptp_rx_filter u_filter (
    .hdr      (rx_hdr),
    .sel      (rx_sel),
    .v1_delay (cfg_v1_delay),
    .src_chk  (cfg_src_chk),
    .hit      (rx_hit)
  );

  assign dir_qual[DIR_RX] = cfg_rx_en && rx_sof && rx_hit;
  assign dir_qual[DIR_TX] = cfg_tx_en && tx_sof && tx_mark;

  for (genvar d = 0; d < NDIR; d++) begin : g_slot
    ptp_stamp_slot #(
      .TIME_W (TIME_W),
      .DROP_W (DROP_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .qual     (dir_qual[d]),
      .clear    (dir_clear[d]),
      .time_now (time_now),
      .valid    (dir_valid[d]),
      .stamp    (dir_stamp[d]),
      .drop_cnt (dir_drop[d]),
      .cap      (dir_cap[d])
    );
  end

  ptp_stamp_readout #(
    .TIME_W (TIME_W),
    .DROP_W (DROP_W)
  ) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .dir_stamp (dir_stamp),
    .dir_valid (dir_valid),
    .dir_drop  (dir_drop),
    .dir_clear (dir_clear),
    .rd_data   (rd_data)
  );

  always_comb irq_n = |dir_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq      = irq_q;
  assign rx_valid = dir_valid[DIR_RX];
  assign tx_valid = dir_valid[DIR_TX];

endmodule

// File: rtl/ptp_stamp_latch_chk.sv
module ptp_stamp_latch_chk
  import ptp_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DROP_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_rx_en,
  input logic                        cfg_tx_en,
  input logic                        rd_en,
  input logic [2:0]                  rd_addr,
  input logic                        rx_valid,
  input logic                        tx_valid,
  input logic                        irq,
  input logic [NDIR-1:0][TIME_W-1:0] dir_stamp,
  input logic [NDIR-1:0][DROP_W-1:0] dir_drop
);

  // R3: a high-word read empties the slot at the next edge
  a_r3_rx_high_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd1 && rx_valid) |=> !rx_valid);

  a_r3_tx_high_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd3 && tx_valid) |=> !tx_valid);

  // R2: a locked slot keeps its stamp
  a_r2_rx_stamp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> $stable(dir_stamp[DIR_RX]));

  a_r2_tx_stamp_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> $stable(dir_stamp[DIR_TX]));

  // R8: a disabled direction never becomes valid
  a_r8_rx_off_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rx_en && !rx_valid) |=> !rx_valid);

  a_r8_tx_off_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_tx_en && !tx_valid) |=> !tx_valid);

  // R9: drop counters only move upwards
  a_r9_rx_drop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    dir_drop[DIR_RX] >= $past(dir_drop[DIR_RX]));

  a_r9_tx_drop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    dir_drop[DIR_TX] >= $past(dir_drop[DIR_TX]));

  // R10: the pulse marks exactly the cycles where a valid flag rises
  a_r10_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ($rose(rx_valid) || $rose(tx_valid)));

endmodule

bind ptp_stamp_latch ptp_stamp_latch_chk #(
  .TIME_W (TIME_W),
  .DROP_W (DROP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rx_en (cfg_rx_en),
  .cfg_tx_en (cfg_tx_en),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rx_valid  (rx_valid),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .dir_stamp (dir_stamp),
  .dir_drop  (dir_drop)
);

// File: tb/ptp_stamp_latch_bench.sv
`timescale 1ns/1ps
module ptp_stamp_latch_bench;

  localparam int TW   = 64;
  localparam int DW   = 3;
  localparam int DMAX = (1 << DW) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_rx_en, cfg_tx_en, cfg_v1_delay, cfg_src_chk;
  logic [1:0]  cfg_rx_sel;
  logic [63:0] time_now;
  logic        rx_sof, tx_sof, tx_mark, rd_en;
  logic [15:0] rx_etype, rx_udp_src, rx_udp_dst;
  logic [7:0]  rx_ip_proto;
  logic [3:0]  rx_ptp_ver, rx_msg_type;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rx_valid, tx_valid, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ptp_stamp_latch #(.TIME_W(TW), .DROP_W(DW)) u_ptp_stamp_latch (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_sel(cfg_rx_sel), .cfg_v1_delay(cfg_v1_delay), .cfg_src_chk(cfg_src_chk),
    .time_now(time_now), .rx_sof(rx_sof), .rx_etype(rx_etype), .rx_ip_proto(rx_ip_proto),
    .rx_udp_src(rx_udp_src), .rx_udp_dst(rx_udp_dst), .rx_ptp_ver(rx_ptp_ver),
    .rx_msg_type(rx_msg_type), .tx_sof(tx_sof), .tx_mark(tx_mark), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_valid(rx_valid), .tx_valid(tx_valid), .irq(irq)
  );

  // time base: advances away from the sampling edge
  always @(negedge clk) time_now <= time_now + 64'd8;

  // ---------------- behavioural reference model ----------------
  bit          m_rxv, m_txv, m_irq;
  logic [63:0] m_rxs, m_txs;
  int          m_rxd, m_txd;
  logic [31:0] m_rd;

  function automatic bit frame_wanted();
    bit udp_ok;
    bit eth_ok;
    udp_ok = (rx_ip_proto == 8'd17) && (rx_udp_dst == 16'd319) &&
             (!cfg_src_chk || rx_udp_src == 16'd319);
    eth_ok = (rx_etype == 16'h88F7);
    if (cfg_rx_sel == 2'd0)
      return udp_ok && rx_ptp_ver == 4'd1 && rx_msg_type == (cfg_v1_delay ? 4'd1 : 4'd0);
    else if (cfg_rx_sel == 2'd1)
      return (udp_ok || eth_ok) && rx_ptp_ver == 4'd2 && rx_msg_type < 4'd4;
    else if (cfg_rx_sel == 2'd2)
      return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit rq, tq, rcap, tcap, rclr, tclr;
    if (!rst_n) begin
      m_rxv = 0; m_txv = 0; m_irq = 0; m_rxs = 0; m_txs = 0;
      m_rxd = 0; m_txd = 0; m_rd = 0;
    end else begin
      rq = rx_sof && cfg_rx_en && frame_wanted();
      tq = tx_sof && tx_mark && cfg_tx_en;
      if (rd_en) begin
        case (rd_addr)
          3'd0: m_rd = m_rxs[31:0];
          3'd1: m_rd = m_rxs[63:32];
          3'd2: m_rd = m_txs[31:0];
          3'd3: m_rd = m_txs[63:32];
          3'd4: m_rd = {30'd0, m_txv, m_rxv};
          3'd5: m_rd = 32'(m_rxd);
          3'd6: m_rd = 32'(m_txd);
          default: m_rd = 32'd0;
        endcase
      end
      rclr = rd_en && rd_addr == 3'd1;
      tclr = rd_en && rd_addr == 3'd3;
      rcap = rq && !m_rxv;
      tcap = tq && !m_txv;
      if (rq && m_rxv && m_rxd < DMAX) m_rxd++;
      if (tq && m_txv && m_txd < DMAX) m_txd++;
      if (rcap) m_rxs = time_now;
      if (tcap) m_txs = time_now;
      m_rxv = m_rxv ? !rclr : rcap;
      m_txv = m_txv ? !tclr : tcap;
      m_irq = rcap || tcap;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rx_valid vs model", 64'(rx_valid), 64'(m_rxv));
      chk("R8 tx_valid vs model", 64'(tx_valid), 64'(m_txv));
      chk("R10 irq vs model", 64'(irq), 64'(m_irq));
      chk("R1 rd_data vs model", 64'(rd_data), 64'(m_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R11 watchdog: got cycle %0d expected finish earlier", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hdr(input logic [15:0] et, input logic [7:0] pr, input logic [15:0] sp,
                     input logic [15:0] dp, input logic [3:0] ver, input logic [3:0] msg);
    rx_etype = et; rx_ip_proto = pr; rx_udp_src = sp; rx_udp_dst = dp;
    rx_ptp_ver = ver; rx_msg_type = msg;
  endtask

  task automatic strobe(input bit do_rx, input bit do_tx, output logic [63:0] t);
    rx_sof = do_rx; tx_sof = do_tx;
    @(posedge clk); t = time_now;
    @(negedge clk); rx_sof = 1'b0; tx_sof = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [63:0] t, t2;
    logic [31:0] d;
    rst_n = 1'b0; time_now = 64'h0000_1234_FFFF_FF00;
    cfg_rx_en = 0; cfg_tx_en = 0; cfg_rx_sel = 2'd3; cfg_v1_delay = 0; cfg_src_chk = 0;
    rx_sof = 0; tx_sof = 0; tx_mark = 0; rd_en = 0; rd_addr = 0;
    hdr(16'h0800, 8'd6, 16'd0, 16'd0, 4'd0, 4'd0);
    idle(3);
    rst_n = 1'b1;
    chk("R11 reset rx_valid", 64'(rx_valid), 0);
    chk("R11 reset tx_valid", 64'(tx_valid), 0);
    chk("R11 reset irq", 64'(irq), 0);
    chk("R11 reset rd_data", 64'(rd_data), 0);
    rd(3'd5, d); chk("R11 reset rx drop count", 64'(d), 0);

    // mode "all" captures anything
    cfg_rx_en = 1; cfg_rx_sel = 2'd2;
    strobe(1, 0, t);
    chk("R6 all-mode capture", 64'(rx_valid), 1);
    chk("R10 irq pulse on capture", 64'(irq), 1);
    idle(1);
    chk("R10 irq one cycle only", 64'(irq), 0);
    rd(3'd0, d); chk("R1 rx low word", 64'(d), 64'(t[31:0]));
    chk("R3 low read keeps valid", 64'(rx_valid), 1);
    strobe(1, 0, t2);
    rd(3'd1, d); chk("R2 stamp kept while locked", 64'(d), 64'(t[63:32]));
    chk("R3 high read clears", 64'(rx_valid), 0);
    rd(3'd5, d); chk("R9 rx drop count", 64'(d), 1);

    // V1 over UDP
    cfg_rx_sel = 2'd0; cfg_v1_delay = 0;
    hdr(16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd1);
    strobe(1, 0, t); chk("R4 V1 wrong message ignored", 64'(rx_valid), 0);
    hdr(16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd0);
    strobe(1, 0, t); chk("R4 V1 sync captured", 64'(rx_valid), 1);
    rd(3'd1, d);
    cfg_v1_delay = 1;
    hdr(16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd1);
    strobe(1, 0, t); chk("R4 V1 delay captured", 64'(rx_valid), 1);
    rd(3'd1, d);
    hdr(16'h88F7, 8'd6, 16'd0, 16'd0, 4'd1, 4'd1);
    strobe(1, 0, t); chk("R4 V1 needs UDP", 64'(rx_valid), 0);

    // V2 events
    cfg_rx_sel = 2'd1;
    hdr(16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd3);
    strobe(1, 0, t); chk("R5 V2 L2 type 3 captured", 64'(rx_valid), 1);
    rd(3'd1, d);
    hdr(16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd8);
    strobe(1, 0, t); chk("R5 V2 general message ignored", 64'(rx_valid), 0);
    hdr(16'h0800, 8'd17, 16'd1234, 16'd319, 4'd1, 4'd0);
    strobe(1, 0, t); chk("R5 V2 mode rejects version 1", 64'(rx_valid), 0);

    // source-port check
    cfg_src_chk = 1;
    hdr(16'h0800, 8'd17, 16'd1234, 16'd319, 4'd2, 4'd0);
    strobe(1, 0, t); chk("R7 wrong source port ignored", 64'(rx_valid), 0);
    hdr(16'h0800, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0);
    strobe(1, 0, t); chk("R7 source port 319 captured", 64'(rx_valid), 1);
    rd(3'd1, d);
    hdr(16'h88F7, 8'd0, 16'd5, 16'd5, 4'd2, 4'd1);
    strobe(1, 0, t); chk("R7 L2 path unaffected", 64'(rx_valid), 1);
    rd(3'd1, d);
    cfg_src_chk = 0;

    // mode none
    cfg_rx_sel = 2'd3;
    strobe(1, 0, t); chk("R6 none-mode ignores", 64'(rx_valid), 0);

    // enables and transmit marking
    cfg_rx_sel = 2'd2; cfg_rx_en = 0;
    strobe(1, 0, t); chk("R8 rx disabled", 64'(rx_valid), 0);
    tx_mark = 1;
    strobe(0, 1, t); chk("R8 tx disabled", 64'(tx_valid), 0);
    cfg_tx_en = 1; tx_mark = 0;
    strobe(0, 1, t); chk("R8 unmarked tx ignored", 64'(tx_valid), 0);
    tx_mark = 1;
    strobe(1, 1, t); chk("R8 marked tx captured", 64'(tx_valid), 1);
    chk("R8 rx stays off", 64'(rx_valid), 0);
    rd(3'd2, d); chk("R1 tx low word", 64'(d), 64'(t[31:0]));
    for (int i = 0; i < 9; i++) strobe(0, 1, t2);
    rd(3'd6, d); chk("R9 tx drop saturates", 64'(d), DMAX);
    rd(3'd4, d); chk("R9 status word", 64'(d), 64'h2);
    rd(3'd7, d); chk("R9 spare address reads zero", 64'(d), 0);
    rd(3'd3, d); chk("R1 tx high word", 64'(d), 64'(t[63:32]));

    // simultaneous captures, then clear racing a strobe
    cfg_rx_en = 1;
    strobe(1, 1, t);
    chk("R10 both capture one pulse", 64'(irq), 1);
    chk("R2 both valid", 64'({rx_valid, tx_valid}), 64'h3);
    rd_en = 1; rd_addr = 3'd1; rx_sof = 1;
    @(negedge clk); rd_en = 0; rx_sof = 0;
    chk("R3 strobe during clear dropped", 64'(rx_valid), 0);
    rd(3'd3, d);

    // randomized phase, checked by the model each clock
    for (int i = 0; i < 3000; i++) begin
      cfg_rx_en    = ($urandom % 8) != 0;
      cfg_tx_en    = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) cfg_rx_sel = 2'($urandom);
      cfg_v1_delay = 1'($urandom);
      cfg_src_chk  = 1'($urandom);
      hdr(($urandom % 2) ? 16'h88F7 : 16'h0800, ($urandom % 2) ? 8'd17 : 8'd6,
          ($urandom % 2) ? 16'd319 : 16'd320, ($urandom % 4) ? 16'd319 : 16'd320,
          ($urandom % 2) ? 4'd1 : 4'd2, 4'($urandom % 10));
      rx_sof  = ($urandom % 3) == 0;
      tx_sof  = ($urandom % 4) == 0;
      tx_mark = 1'($urandom);
      rd_en   = ($urandom % 3) == 0;
      rd_addr = 3'($urandom);
      @(negedge clk);
    end
    rx_sof = 0; tx_sof = 0; rd_en = 0;
    idle(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule